// File: doc/BRIEF.md
# Streaming Matrix Transpose Switch

This block sits between the row pass and the column pass of a two-dimensional FFT. It takes a square matrix of N×N complex samples, streamed in row-major order at P samples per clock. It streams the same matrix out in transposed order, also row-major and also P samples per clock. Each sample is a complex value with a 16-bit fixed-point real part and a 16-bit fixed-point imaginary part. The block treats the 32 bits as one word and never computes on them.

The reordering is done in three steps. A P×P rotating switch spreads each incoming word across P lane memories. Each lane memory then reorders its part of the frame in time. A second P×P rotating switch gathers the words that the memories read out. The switch settings and memory addresses are fixed functions of the word position in the frame, and there is no run-time configuration.

Each lane memory holds two frames. This lets one frame be read out while the next is written, so frames can follow each other with no idle cycles. There is no ready signal. The caller marks the first word of each frame with a start flag, and may leave idle cycles inside a frame.

Top module: `tpose_net`

## Requirements
- R1: While reset is held and after it is released, and until a frame completes, `outValid` and `outSof` stay low.
- R2: Lane j of input word t carries matrix element (r,c), where r·N+c = t·P+j. Lane j of output word t of a frame carries input element (c,r), where r·N+c = t·P+j. Lane j occupies bits j·32 and upward, with the real part in the low 16 bits.
- R3: Take the clock edge that accepts the last (N·N/P-th) word of a frame. The first output word of that frame appears after the third clock edge following it. The remaining N·N/P−1 words follow on consecutive cycles.
- R4: `outSof` is high together with the first output word of every frame and is low at all other times.
- R5: Frames whose input words follow each other with no idle cycles are output with no idle cycles between them, and each frame is still correct.
- R6: Idle cycles (`inValid` low) inside an input frame do not change that frame's output data.
- R7: After reset, words with `inValid` high are ignored until the first word that also has `inSof` high, and they produce no output.
- R8: An input word with `inSof` high restarts the frame at position 0. A partly received frame is then discarded and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input word present this cycle |
| inSof | input | 1 | Input word is the first of a frame |
| inData | input | P·32 | P complex samples, lane j at bits j·32 and upward |
| outValid | output | 1 | Output word present this cycle |
| outSof | output | 1 | Output word is the first of a transposed frame |
| outData | output | P·32 | P transposed complex samples, same lane layout as the input |

## Verification
The hard case is when the writing of one frame and the reading of the previous frame use the lane memories in the same cycles. Within that case, the final read of one frame can coincide with the start of the next read. The bench provokes both by streaming frames back to back, and then frames with random idle gaps and a restarted partial frame. A behavioural model built from queues predicts, on every cycle, whether an output word is due and what its lanes and start flag must be. Any word that arrives early, late or wrong is reported on that cycle.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  localparam int POS_W = 16;

  typedef struct packed {
    logic             wrEn;
    logic             wrBuf;
    logic [POS_W-1:0] wrPos;
    logic             rdEn;
    logic             rdSof;
    logic             rdBuf;
    logic [POS_W-1:0] rdPos;
  } ctrl_strobes_t;

  // Input lane that feeds memory bank `bank` at write position `pos`.
  // Row r of the matrix is rotated by r mod P so that one column later
  // lands in P distinct banks.
  function automatic int wrSrcLane(int n, int p, int pos, int bank);
    int row;
    row = pos / (n / p);
    return (bank - (row % p) + p) % p;
  endfunction

  // Word address inside a frame that bank `bank` reads at read position `pos`.
  function automatic int rdBankAddr(int n, int p, int pos, int bank);
    int outRow, rowBase, lane;
    outRow  = pos / (n / p);
    rowBase = (pos % (n / p)) * p;
    lane    = (bank - (outRow % p) + p) % p;
    return (rowBase + lane) * (n / p) + outRow / p;
  endfunction

  // Rotation the gather switch applies at read position `pos`.
  function automatic int rdRotate(int n, int p, int pos);
    return (pos / (n / p)) % p;
  endfunction

endpackage

// File: rtl/tpose_bank_mem.sv
module tpose_bank_mem #(
  parameter int SW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [SW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [SW-1:0] q
);
  logic [SW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
    q <= store[ra];
  end
endmodule

// File: rtl/tpose_ctrl.sv
module tpose_ctrl import tpose_pkg::*; #(
  parameter int N = 16,
  parameter int P = 4,
  localparam int F = N * N / P
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSof,
  output ctrl_strobes_t strobes
);
  logic             aligned;
  logic             accept;
  logic [POS_W-1:0] wrPos;
  logic [POS_W-1:0] curPos;
  logic             wrBuf;
  logic             lastWord;
  logic             pendStart;
  logic             pendBuf;
  logic             rdActive;
  logic [POS_W-1:0] rdPos;
  logic             rdBuf;

  assign accept   = inValid && (aligned || inSof);
  assign curPos   = inSof ? '0 : wrPos;
  assign lastWord = accept && (int'(curPos) == F - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aligned   <= 1'b0;
      wrPos     <= '0;
      wrBuf     <= 1'b0;
      pendStart <= 1'b0;
      pendBuf   <= 1'b0;
    end else begin
      pendStart <= lastWord;
      if (inValid && inSof) aligned <= 1'b1;
      if (accept) begin
        if (lastWord) begin
          wrPos   <= '0;
          wrBuf   <= ~wrBuf;
          pendBuf <= wrBuf;
        end else begin
          wrPos <= curPos + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdPos    <= '0;
      rdBuf    <= 1'b0;
    end else if (pendStart) begin
      rdActive <= 1'b1;
      rdPos    <= '0;
      rdBuf    <= pendBuf;
    end else if (rdActive) begin
      if (int'(rdPos) == F - 1) rdActive <= 1'b0;
      else rdPos <= rdPos + 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn  = accept;
    strobes.wrBuf = wrBuf;
    strobes.wrPos = curPos;
    strobes.rdEn  = rdActive;
    strobes.rdSof = rdActive && (rdPos == '0);
    strobes.rdBuf = rdBuf;
    strobes.rdPos = rdPos;
  end

  // A new read may only begin as the running one issues its final word.
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendStart && rdActive) |-> (int'(rdPos) == F - 1));

  // Nothing is read out before the first start-of-frame word.
  assert_pre_sof_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !aligned |-> (!rdActive && !pendStart));
endmodule

// File: rtl/tpose_datapath.sv
module tpose_datapath import tpose_pkg::*; #(
  parameter int N  = 16,
  parameter int P  = 4,
  parameter int SW = 32,
  localparam int F  = N * N / P,
  localparam int AW = $clog2(2 * F)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_strobes_t   strobes,
  input  logic [P*SW-1:0] inData,
  output logic            outValid,
  output logic            outSof,
  output logic [P*SW-1:0] outData
);
  logic [SW-1:0]    inLane  [P];
  logic [SW-1:0]    s1Data  [P];
  logic [SW-1:0]    bankQ   [P];
  logic [AW-1:0]    rdAddr  [P];
  logic             s1En;
  logic [AW-1:0]    s1Addr;
  logic             p2Valid;
  logic             p2Sof;
  logic [POS_W-1:0] p2Rot;

  for (genvar j = 0; j < P; j++) begin : g_inLane
    assign inLane[j] = inData[j*SW +: SW];
  end

  // Scatter switch: rotate the row onto the banks and register it.
  always_ff @(posedge clk) begin
    if (!rstN) s1En <= 1'b0;
    else       s1En <= strobes.wrEn;
    s1Addr <= AW'(int'(strobes.wrBuf) * F + int'(strobes.wrPos));
    for (int b = 0; b < P; b++)
      s1Data[b] <= inLane[wrSrcLane(N, P, int'(strobes.wrPos), b)];
  end

  always_comb begin
    for (int b = 0; b < P; b++)
      rdAddr[b] = AW'(int'(strobes.rdBuf) * F +
                      rdBankAddr(N, P, int'(strobes.rdPos), b));
  end

  for (genvar b = 0; b < P; b++) begin : g_bank
    tpose_bank_mem #(.SW(SW), .DEPTH(2 * F)) i_bank (
      .clk (clk),
      .we  (s1En),
      .wa  (s1Addr),
      .wd  (s1Data[b]),
      .ra  (rdAddr[b]),
      .q   (bankQ[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p2Valid  <= 1'b0;
      p2Sof    <= 1'b0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
    end else begin
      p2Valid  <= strobes.rdEn;
      p2Sof    <= strobes.rdSof;
      outValid <= p2Valid;
      outSof   <= p2Sof;
    end
    p2Rot <= POS_W'(rdRotate(N, P, int'(strobes.rdPos)));
  end

  // Gather switch: undo the bank rotation of the column being read.
  always_ff @(posedge clk) begin
    for (int j = 0; j < P; j++)
      outData[j*SW +: SW] <= bankQ[(int'(p2Rot) + j) % P];
  end

  assert_sof_with_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |-> ##2 outValid);
endmodule

// File: rtl/tpose_net.sv
module tpose_net import tpose_pkg::*; #(
  parameter int N = 16,
  parameter int P = 4,
  parameter int W = 16,
  localparam int SW = 2 * W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inSof,
  input  logic [P*SW-1:0] inData,
  output logic            outValid,
  output logic            outSof,
  output logic [P*SW-1:0] outData
);
  ctrl_strobes_t strobes;

  tpose_ctrl #(.N(N), .P(P)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .strobes (strobes)
  );

  tpose_datapath #(.N(N), .P(P), .SW(SW)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inData   (inData),
    .outValid (outValid),
    .outSof   (outSof),
    .outData  (outData)
  );
endmodule

// File: tb/test_tpose_net.sv
module test_tpose_net;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int P  = 4;
  localparam int SW = 32;
  localparam int F  = N * N / P;
  localparam int DW = P * SW;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inSof = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic          outSof;
  logic [DW-1:0] outData;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit running = 1'b0;
  string phaseTag = "R7";

  // Behavioural reference state.
  bit            mAligned = 1'b0;
  int            mPos = 0;
  logic [DW-1:0] mFrame [F];
  logic [DW-1:0] expData [$];
  bit            expSof [$];
  int            expCyc [$];

  tpose_net #(.N(N), .P(P), .W(16)) i_tpose_net (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inData(inData),
    .outValid(outValid), .outSof(outSof), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
      summary();
    end
  end

  // Queue the transposed frame; first word visible three edges after the
  // edge that samples the last input word (R3).
  task automatic pushFrame(input int dueFirst);
    for (int i = 0; i < F; i++) begin
      logic [DW-1:0] w;
      for (int j = 0; j < P; j++) begin
        int k = i * P + j;
        int s = (k % N) * N + (k / N);
        w[j*SW +: SW] = mFrame[s / P][(s % P)*SW +: SW];
      end
      expData.push_back(w);
      expSof.push_back(i == 0);
      expCyc.push_back(dueFirst + i);
    end
  endtask

  task automatic drive(input bit v, input bit s, input logic [DW-1:0] d);
    @(negedge clk);
    inValid = v; inSof = s; inData = d;
    if (v && s) begin mAligned = 1'b1; mPos = 0; end
    if (v && mAligned) begin
      mFrame[mPos] = d;
      if (mPos == F - 1) begin
        pushFrame(cyc + 4);
        mPos = 0;
      end else mPos++;
    end
  endtask

  function automatic logic [DW-1:0] makeWord(int mode, int pos, int tag);
    logic [DW-1:0] w;
    for (int j = 0; j < P; j++) begin
      if (mode == 0) w[j*SW +: SW] = $urandom;
      else w[j*SW +: SW] = {16'(tag), 16'(pos * P + j)};
    end
    return w;
  endfunction

  task automatic sendFrame(int mode, int gapPct, int tag);
    for (int pos = 0; pos < F; pos++) begin
      while (gapPct > 0 && ($urandom % 100) < gapPct) drive(1'b0, 1'b0, $urandom);
      drive(1'b1, pos == 0, makeWord(mode, pos, tag));
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (running) begin
      bit due;
      due = (expCyc.size() > 0) && (expCyc[0] == cyc);
      compared++;
      if (outValid !== due) begin
        mismatched++;
        $display("FAIL %s: outValid actual %0b expected %0b at cycle %0d",
                 due ? "R3" : phaseTag, outValid, due, cyc);
      end
      if (due) begin
        compared++;
        if (outData !== expData[0]) begin
          mismatched++;
          $display("FAIL R2: outData actual %h expected %h", outData, expData[0]);
        end
        compared++;
        if (outSof !== expSof[0]) begin
          mismatched++;
          $display("FAIL R4: outSof actual %0b expected %0b", outSof, expSof[0]);
        end
        void'(expData.pop_front());
        void'(expSof.pop_front());
        void'(expCyc.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (outValid !== 1'b0 || outSof !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: outValid/outSof actual %0b%0b expected 00 in reset", outValid, outSof);
    end
    rstN = 1'b1;
    running = 1'b1;
    // R7: stray words with no start flag, more than a frame's worth.
    phaseTag = "R7";
    for (int i = 0; i < F + 8; i++) drive(1'b1, 1'b0, $urandom);
    drive(1'b0, 1'b0, '0);
    // R1, R2, R3: one ramp frame then one random frame, separated.
    phaseTag = "R1";
    sendFrame(1, 0, 1);
    phaseTag = "R3";
    repeat (10) drive(1'b0, 1'b0, '0);
    sendFrame(0, 0, 2);
    repeat (3) drive(1'b0, 1'b0, '0);
    // R5: back-to-back frames with no idle cycle.
    phaseTag = "R5";
    for (int f = 0; f < 4; f++) sendFrame(f % 2, 0, 10 + f);
    // R6: idle gaps inside frames.
    phaseTag = "R6";
    for (int f = 0; f < 2; f++) sendFrame(0, 30, 20 + f);
    // R8: partial frame restarted by a new start flag.
    phaseTag = "R8";
    for (int pos = 0; pos < 20; pos++) drive(1'b1, pos == 0, makeWord(0, pos, 30));
    sendFrame(1, 0, 31);
    drive(1'b1, 1'b1, makeWord(0, 0, 32));
    for (int pos = 1; pos < F - 1; pos++) drive(1'b1, 1'b0, makeWord(0, pos, 32));
    drive(1'b0, 1'b0, '0);
    repeat (2 * F + 10) drive(1'b0, 1'b0, '0);
    compared++;
    if (expCyc.size() != 0) begin
      mismatched++;
      $display("FAIL R3: pending expected words actual %0d expected 0", expCyc.size());
    end
    summary();
  end
endmodule